// File: doc/BRIEF.md
# Slow-Register Host Interface with Adaptive Wait States

This block sits between a 32-bit host bus and a register file whose internal writes take a fixed and long time to settle. The host issues word-aligned reads and writes with a valid/ready handshake. Only the low 16 data bits reach the register file. Whenever a request would disturb an internal write that is still settling, the block pulls ready low. It releases ready in the first cycle in which the request is safe.

Wait states are not a fixed count. One saturating timer tracks how long ago the last slow internal write started, so a host that has been idle or busy elsewhere sees no stall at all. Writes need the internal write time to have passed. Reads need that time plus a small set-up margin. Both times are given in nanoseconds and converted to clock cycles, rounding up, from a clock-period parameter.

A 32-bit increment value is loaded as two 16-bit writes. The high half first goes to a staging register, which never stalls and never starts an internal write. A later write to an increment-low register then stores its own 16 bits and the staged half together, as one internal write. The register array here stands in for twelve channel blocks of eight registers each, one multi-channel block and three global registers.

Top module: `slowreg_host_if`

## Requirements
- R1: A read returns the addressed 16-bit register in bits 15:0 and zeros in bits 31:16. Address bits 1:0 have no effect on which register is read.
- R2: A write to any address other than the staging address (offset 0x1A4) is accepted no earlier than WR_CYC = ceil(WRITE_NS/CLK_NS) cycles after the previous such write was accepted.
- R3: A read is accepted no earlier than RD_CYC = ceil(READ_NS/CLK_NS) cycles after the last non-staging write was accepted.
- R4: A write to the staging address is accepted in the cycle it is presented. It changes no readable register and does not restart the wait timer.
- R5: A write to an increment-low register stores write data bits 15:0 at its own address and the staged half at the next word (address + 4), in the same cycle. Increment-low registers are those at offsets 0x08 (carrier) and 0x10 (code) within each 0x20-byte block: the twelve channel blocks from offset 0x000 and the multi-channel block at 0x180.
- R6: Any other mapped write stores only write data bits 15:0 at its own word and leaves neighbouring words unchanged. Bits 31:16 are discarded.
- R7: There is no fixed wait count. If the required time has already passed, ready is high in the first cycle of the request. Otherwise ready rises exactly when the required time is reached.
- R8: After synchronous reset, every register reads zero and the first access proceeds without a stall.
- R9: The staging register keeps its value after a commit, so later increment-low writes reuse the last staged half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Request present; must stay stable while ready is low |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| host_wdata | input | 32 | Write data; only bits 15:0 are used |
| host_ready | output | 1 | Request may complete this cycle |
| host_rdata | output | 32 | Read data for the presented read address |

## Verification
The bench builds the block with its default parameters: a 20 ns clock period, a 300 ns write time and a 314 ns read time. These give WR_CYC = 15 and RD_CYC = 16. The one-cycle gap between the two limits makes a read that follows a write wait exactly one cycle longer than a second write, so the bench can tell which limit the design applied. Fifteen cycles are short enough to step idle gaps across the whole window. A gap of ten idle cycles lands part-way through it, and a gap of twenty lands past it.

// File: rtl/slowreg_pkg.sv
package slowreg_pkg;

    localparam int HOST_W        = 32;
    localparam int REG_W         = 16;
    localparam int CARRIER_LO_SUB = 2;
    localparam int CODE_LO_SUB    = 4;
    localparam int STAGE_OFS      = 9;
    localparam int GLOBAL_FIRST   = 11;
    localparam int GLOBAL_STRIDE  = 2;
    localparam int NUM_GLOBALS    = 3;
    localparam int TAIL_WORDS     = 16;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_PLAIN = 2'd1,
        KIND_PAIR  = 2'd2,
        KIND_STAGE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic             en;
        logic             pair;
        logic [REG_W-1:0] lo;
        logic [REG_W-1:0] hi;
    } commit_t;

    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/slowreg_decode.sv
module slowreg_decode
    import slowreg_pkg::*;
#(
    parameter int WORD_W      = 7,
    parameter int NUM_CH      = 12,
    parameter int REGS_PER_CH = 8
) (
    input  logic [WORD_W-1:0] word,
    output reg_kind_e         kind
);
    localparam int SUB_W      = $clog2(REGS_PER_CH);
    localparam int MULTI_BASE = NUM_CH * REGS_PER_CH;
    localparam int BLOCK_END  = MULTI_BASE + REGS_PER_CH;
    localparam int STAGE_WORD = MULTI_BASE + STAGE_OFS;

    logic [SUB_W-1:0] sub;
    logic             in_blocks;
    logic             is_global;

    assign sub       = word[SUB_W-1:0];
    assign in_blocks = (word < WORD_W'(BLOCK_END));

    always_comb begin
        is_global = 1'b0;
        for (int g = 0; g < NUM_GLOBALS; g++) begin
            if (word == WORD_W'(MULTI_BASE + GLOBAL_FIRST + GLOBAL_STRIDE * g))
                is_global = 1'b1;
        end
    end

    always_comb begin
        if (word == WORD_W'(STAGE_WORD))
            kind = KIND_STAGE;
        else if (in_blocks && (sub == SUB_W'(CARRIER_LO_SUB) || sub == SUB_W'(CODE_LO_SUB)))
            kind = KIND_PAIR;
        else if (in_blocks || is_global)
            kind = KIND_PLAIN;
        else
            kind = KIND_NONE;
    end

endmodule

// File: rtl/slowreg_timer.sv
module slowreg_timer #(
    parameter int WR_CYC = 15,
    parameter int RD_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic write_ok,
    output logic read_ok
);
    localparam int SAT_CYC = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
    localparam int CNT_W   = $clog2(SAT_CYC + 1);

    logic [CNT_W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst)
            elapsed <= CNT_W'(SAT_CYC);
        else if (start)
            elapsed <= CNT_W'(1);
        else if (elapsed < CNT_W'(SAT_CYC))
            elapsed <= elapsed + CNT_W'(1);
    end

    assign write_ok = (elapsed >= CNT_W'(WR_CYC));
    assign read_ok  = (elapsed >= CNT_W'(RD_CYC));

endmodule

// File: rtl/slowreg_regfile.sv
module slowreg_regfile
    import slowreg_pkg::*;
#(
    parameter int NUM_WORDS = 112,
    parameter int WORD_W    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  commit_t           commit,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [WORD_W-1:0] rd_word,
    output logic [REG_W-1:0]  rd_data
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [REG_W-1:0] mem [NUM_WORDS];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] wr_idx_hi;
    logic [IDX_W-1:0] rd_idx;
    logic             wr_in_range;
    logic             rd_in_range;

    assign wr_idx      = IDX_W'(wr_word);
    assign wr_idx_hi   = wr_idx + IDX_W'(1);
    assign rd_idx      = IDX_W'(rd_word);
    assign wr_in_range = (wr_word < WORD_W'(NUM_WORDS));
    assign rd_in_range = (rd_word < WORD_W'(NUM_WORDS));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++)
                mem[i] <= '0;
        end else if (commit.en && wr_in_range) begin
            mem[wr_idx] <= commit.lo;
            if (commit.pair)
                mem[wr_idx_hi] <= commit.hi;
        end
    end

    assign rd_data = rd_in_range ? mem[rd_idx] : '0;

endmodule

// File: rtl/slowreg_host_if.sv
module slowreg_host_if
    import slowreg_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int CLK_NS      = 20,
    parameter int WRITE_NS    = 300,
    parameter int READ_NS     = 314,
    parameter int NUM_CH      = 12,
    parameter int REGS_PER_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic              host_ready,
    output logic [31:0]       host_rdata
);
    localparam int WORD_W    = ADDR_W - 2;
    localparam int WR_CYC    = ns_to_cycles(WRITE_NS, CLK_NS);
    localparam int RD_CYC    = max_int(ns_to_cycles(READ_NS, CLK_NS), 1);
    localparam int NUM_WORDS = NUM_CH * REGS_PER_CH + TAIL_WORDS;

    logic [WORD_W-1:0] word;
    reg_kind_e         kind;
    logic              write_ok;
    logic              read_ok;
    logic              fire;
    logic              slow_start;
    logic [REG_W-1:0]  stage_q;
    logic [REG_W-1:0]  rd_data;
    commit_t           commit;
    logic              unused_bits;

    assign word        = host_addr[ADDR_W-1:2];
    assign unused_bits = ^{host_addr[1:0], host_wdata[31:16]};

    slowreg_decode #(
        .WORD_W      (WORD_W),
        .NUM_CH      (NUM_CH),
        .REGS_PER_CH (REGS_PER_CH)
    ) i_decode (
        .word (word),
        .kind (kind)
    );

    slowreg_timer #(
        .WR_CYC (WR_CYC),
        .RD_CYC (RD_CYC)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (slow_start),
        .write_ok (write_ok),
        .read_ok  (read_ok)
    );

    always_comb begin
        if (!host_write)
            host_ready = read_ok;
        else if (kind == KIND_STAGE)
            host_ready = 1'b1;
        else
            host_ready = write_ok;
    end

    assign fire       = host_valid && host_ready;
    assign slow_start = fire && host_write && (kind != KIND_STAGE);

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else if (fire && host_write && kind == KIND_STAGE)
            stage_q <= host_wdata[REG_W-1:0];
    end

    always_comb begin
        commit.en   = slow_start && (kind == KIND_PLAIN || kind == KIND_PAIR);
        commit.pair = (kind == KIND_PAIR);
        commit.lo   = host_wdata[REG_W-1:0];
        commit.hi   = stage_q;
    end

    slowreg_regfile #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) i_regfile (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .wr_word (word),
        .rd_word (word),
        .rd_data (rd_data)
    );

    assign host_rdata = {{(HOST_W-REG_W){1'b0}}, rd_data};

endmodule

// File: rtl/slowreg_host_if_chk.sv
module slowreg_host_if_chk
    import slowreg_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int CLK_NS      = 20,
    parameter int WRITE_NS    = 300,
    parameter int READ_NS     = 314,
    parameter int NUM_CH      = 12,
    parameter int REGS_PER_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              host_valid,
    input logic              host_write,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_ready,
    input logic [31:0]       host_rdata
);
    localparam int WR_CYC  = ns_to_cycles(WRITE_NS, CLK_NS);
    localparam int RD_CYC  = max_int(ns_to_cycles(READ_NS, CLK_NS), 1);
    localparam int SAT_CYC = max_int(WR_CYC, RD_CYC);
    localparam int CNT_W   = $clog2(SAT_CYC + 1);
    localparam int STAGE_W = NUM_CH * REGS_PER_CH + STAGE_OFS;

    logic             is_stage;
    logic             slow_acc;
    logic [CNT_W-1:0] since;

    assign is_stage = (host_addr[ADDR_W-1:2] == (ADDR_W-2)'(STAGE_W));
    assign slow_acc = host_valid && host_ready && host_write && !is_stage;

    always_ff @(posedge clk) begin
        if (rst)
            since <= CNT_W'(SAT_CYC);
        else if (slow_acc)
            since <= CNT_W'(1);
        else if (since < CNT_W'(SAT_CYC))
            since <= since + CNT_W'(1);
    end

    assert_write_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        slow_acc |-> (since >= CNT_W'(WR_CYC)));

    assert_read_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_ready && !host_write) |-> (since >= CNT_W'(RD_CYC)));

    assert_stage_no_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_write && is_stage) |-> host_ready);

    assert_no_extra_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_ready) |->
            (host_write ? (since < CNT_W'(WR_CYC)) : (since < CNT_W'(RD_CYC))));

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_write) |-> (host_rdata[31:16] == 16'h0000));

endmodule

bind slowreg_host_if slowreg_host_if_chk #(
    .ADDR_W      (ADDR_W),
    .CLK_NS      (CLK_NS),
    .WRITE_NS    (WRITE_NS),
    .READ_NS     (READ_NS),
    .NUM_CH      (NUM_CH),
    .REGS_PER_CH (REGS_PER_CH)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .host_valid (host_valid),
    .host_write (host_write),
    .host_addr  (host_addr),
    .host_ready (host_ready),
    .host_rdata (host_rdata)
);

// File: tb/test_slowreg_host_if.sv
`timescale 1ns/1ps
module test_slowreg_host_if;

    localparam int ADDR_W   = 9;
    localparam int CLK_NS   = 20;
    localparam int WRITE_NS = 300;
    localparam int READ_NS  = 314;
    localparam int WR       = (WRITE_NS + CLK_NS - 1) / CLK_NS;
    localparam int RD       = (READ_NS + CLK_NS - 1) / CLK_NS;
    localparam logic [ADDR_W-1:0] STAGE_A = 9'h1A4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_valid = 1'b0;
    logic              host_write = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic              host_ready;
    logic [31:0]       host_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    slowreg_host_if #(
        .ADDR_W   (ADDR_W),
        .CLK_NS   (CLK_NS),
        .WRITE_NS (WRITE_NS),
        .READ_NS  (READ_NS)
    ) i_slowreg_host_if (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .host_write (host_write),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_ready (host_ready),
        .host_rdata (host_rdata)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          output int waits, output logic [31:0] rdat);
        @(negedge clk);
        host_valid = 1'b1;
        host_write = wr;
        host_addr  = a;
        host_wdata = d;
        waits      = 0;
        #1;
        while (!host_ready) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rdat = host_rdata;
        @(posedge clk);
        #1;
        host_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        int w; logic [31:0] r;
        access(1'b0, 9'h000, 32'h0, w, r);
        check("R8", "reset read waits", w, 0);
        check("R8", "reset read data", int'(r), 0);
        access(1'b0, 9'h19C, 32'h0, w, r);
        check("R8", "reset multi-block data", int'(r), 0);
    endtask

    task automatic t_plain;
        int w; logic [31:0] r;
        access(1'b1, 9'h020, 32'hDEAD5A5A, w, r);
        check("R7", "write after long idle waits", w, 0);
        access(1'b0, 9'h020, 32'h0, w, r);
        check("R3", "read after write waits", w, RD - 1);
        check("R6", "plain write keeps low half", int'(r), 32'h00005A5A);
        access(1'b0, 9'h023, 32'h0, w, r);
        check("R1", "addr bits 1:0 ignored", int'(r), 32'h00005A5A);
        access(1'b0, 9'h024, 32'h0, w, r);
        check("R6", "neighbour of plain write untouched", int'(r), 0);
        access(1'b1, 9'h1AC, 32'hFFFF0777, w, r);
        access(1'b0, 9'h1AC, 32'h0, w, r);
        check("R6", "global register write", int'(r), 32'h00000777);
    endtask

    task automatic t_b2b;
        int w; logic [31:0] r;
        access(1'b1, 9'h040, 32'h00001111, w, r);
        access(1'b1, 9'h044, 32'h12342222, w, r);
        check("R2", "back-to-back write waits", w, WR - 1);
        access(1'b0, 9'h040, 32'h0, w, r);
        check("R2", "first of pair stored", int'(r), 32'h00001111);
        access(1'b0, 9'h044, 32'h0, w, r);
        check("R2", "second of pair stored", int'(r), 32'h00002222);
    endtask

    task automatic t_pair;
        int w; logic [31:0] r;
        access(1'b1, 9'h060, 32'h00000001, w, r);
        access(1'b1, STAGE_A, 32'hAAAA1357, w, r);
        check("R4", "staging write waits", w, 0);
        access(1'b0, 9'h06C, 32'h0, w, r);
        check("R4", "read after staging keeps write timer", w, RD - 2);
        check("R4", "staging leaves high word unchanged", int'(r), 0);
        access(1'b0, STAGE_A, 32'h0, w, r);
        check("R4", "staging address reads zero", int'(r), 0);
        access(1'b1, 9'h068, 32'hFFFF2468, w, r);
        access(1'b0, 9'h068, 32'h0, w, r);
        check("R5", "carrier low stored", int'(r), 32'h00002468);
        access(1'b0, 9'h06C, 32'h0, w, r);
        check("R5", "carrier high from staging", int'(r), 32'h00001357);
        access(1'b1, 9'h080, 32'h00000002, w, r);
        access(1'b1, STAGE_A, 32'h00009ABC, w, r);
        check("R4", "second staging write waits", w, 0);
        access(1'b1, 9'h090, 32'h00000BEE, w, r);
        check("R4", "low write after staging waits", w, WR - 2);
        access(1'b0, 9'h094, 32'h0, w, r);
        check("R5", "code high from staging", int'(r), 32'h00009ABC);
    endtask

    task automatic t_reuse;
        int w; logic [31:0] r;
        access(1'b1, 9'h188, 32'h00004321, w, r);
        access(1'b0, 9'h18C, 32'h0, w, r);
        check("R9", "multi block reuses staged half", int'(r), 32'h00009ABC);
        access(1'b1, 9'h170, 32'h00000055, w, r);
        access(1'b0, 9'h174, 32'h0, w, r);
        check("R9", "last channel reuses staged half", int'(r), 32'h00009ABC);
        access(1'b0, 9'h170, 32'h0, w, r);
        check("R5", "last channel code low", int'(r), 32'h00000055);
    endtask

    task automatic t_idle;
        int w; logic [31:0] r;
        access(1'b1, 9'h0A0, 32'h00000003, w, r);
        idle(10);
        access(1'b1, 9'h0A4, 32'h00000004, w, r);
        check("R7", "write after 10 idle waits", w, WR - 11);
        idle(10);
        access(1'b0, 9'h0A4, 32'h0, w, r);
        check("R7", "read after 10 idle waits", w, RD - 11);
        access(1'b1, 9'h0A8, 32'h00000005, w, r);
        idle(20);
        access(1'b1, 9'h0AC, 32'h00000006, w, r);
        check("R7", "write after 20 idle waits", w, 0);
        idle(20);
        access(1'b0, 9'h0AC, 32'h0, w, r);
        check("R7", "read after 20 idle waits", w, 0);
        check("R6", "idle write stored", int'(r), 32'h00000006);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_plain();
        t_b2b();
        t_pair();
        t_reuse();
        t_idle();
        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule